// File: doc/BRIEF.md
# Rotating-Activation MAC Tile with Partial-Sum Accumulation

This block is a compute tile that sits right next to a small single-port SRAM subarray. It holds one row of activations in a register that rotates by one lane per step. It also holds one row of weights, where each lane carries the same-position weight of a different kernel. A bank of lane multipliers pairs the two rows lane by lane. Each step yields one diagonal of output partial sums. The tile adds that diagonal onto one row of a block of partial-sum rows in the subarray with a read-modify-write.

A job starts from three row addresses: the activation row, the first of several consecutive weight rows, and the base of the partial-sum block. A clear flag is also given. The tile fetches the activation row once and keeps it for the whole job. For each weight row, it runs one step per lane, rotating the activation register right after every step. After a full set of steps the activations are back in their original order and the next weight row is loaded. Every subarray access goes through one port, so each step is split into a read phase and a write phase. When the tile is idle, a host port gives plain row reads and writes to the subarray, which is how operands are placed and results collected.

Top module: `shift_mac_tile`

## Requirements
- R1: After reset, `busy` and `done` are low.
- R2: A `start` sampled while idle latches the three row addresses and `clear`, and `busy` is high from the next cycle. A `start` while busy has no effect: the job keeps its timing and no second job follows.
- R3: `done` is high for exactly one cycle, 1 + WROWS*(1 + 2*LANES) cycles after the start edge (196 with defaults). `busy` stays high up to and including that cycle and is low from the next one.
- R4: Lane i of an activation or weight row is bits [i*DATA_W +: DATA_W]. Lane i of a partial-sum row is bits [i*PSUM_W +: PSUM_W]. Once the job ends, lane i of partial-sum row `psum_row`+s (s = 0..LANES-1) has gained the sum over weight rows j = 0..WROWS-1 of act[(i - s) mod LANES] * wgt_row+j[i]. This is the right rotation with wrap from the last lane to lane 0.
- R5: With `clear` high, the prior contents of the partial-sum rows are treated as zero. With `clear` low, the job's sums are added onto the existing contents.
- R6: Activations and weights are DATA_W-bit two's complement. Partial sums are PSUM_W-bit two's complement and wrap modulo 2^PSUM_W.
- R7: While idle, `host_en` with `host_we` writes `host_wdata` to row `host_addr`. `host_en` without `host_we` returns that row on `host_rdata` one cycle later.
- R8: Host accesses made while `busy` is high are ignored and change no row.
- R9: A job writes only rows `psum_row` .. `psum_row`+LANES-1. The activation and weight rows and all other rows keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a job (taken only while idle) |
| clear | input | 1 | Treat prior partial sums as zero for this job |
| act_row | input | AW | Row address of the activation row |
| wgt_row | input | AW | Address of the first of WROWS consecutive weight rows |
| psum_row | input | AW | Base of the LANES partial-sum rows |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| host_en | input | 1 | Host row access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | AW | Host row address |
| host_wdata | input | LANES*PSUM_W | Host write data |
| host_rdata | output | LANES*PSUM_W | Host read data, valid one cycle after a read |

## Verification
The control outputs follow a fixed schedule. The bench therefore counts cycles from the start edge and compares `busy` and `done` on every cycle against a predicted timeline. `done` is due exactly 196 cycles after that edge and `busy` drops one cycle later. Host read data is due one cycle after the request, so each readback samples on the falling edge that follows the request cycle. The accumulated partial sums come from a behavioural model of memory rows. They are compared only after `done`, by reading every row back through the host port. This catches rotation direction, the clear path, overflow wrap, stray writes, and host writes that were wrongly accepted mid-job.

// File: rtl/smt_pkg.sv
// Package: shared types for the rotating-activation MAC tile.
// Assumes: nothing beyond the 1800-2017 language.
package smt_pkg;

    // Sequencer phases; each step of a job spends one cycle in RDP and one in WRP.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RDA  = 3'd1,
        ST_RDW  = 3'd2,
        ST_RDP  = 3'd3,
        ST_WRP  = 3'd4,
        ST_DONE = 3'd5
    } tile_state_e;

endpackage

// File: rtl/smt_subarray.sv
// Module: smt_subarray
// Single-port synchronous row memory. One access per cycle: a write stores
// the row, a read registers it onto rdata for the next cycle.
// Assumes: no reset on the storage; rdata keeps its value on writes and idle cycles.
module smt_subarray #(
    parameter int DEPTH = 64,
    parameter int ROW_W = 768,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [ROW_W-1:0] wdata,
    output logic [ROW_W-1:0] rdata
);

    logic [ROW_W-1:0] store [DEPTH];

    // Store a row on a write access.
    always_ff @(posedge clk) begin
        if (en && we) begin
            store[addr] <= wdata;
        end
    end

    // Register the addressed row on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/smt_act_rotator.sv
// Module: smt_act_rotator
// Activation row register. Loads a full row, or rotates right by one lane
// (lane i takes lane i-1, lane 0 takes the last lane).
// Assumes: load and rot are never high together; load wins if they are.
module smt_act_rotator #(
    parameter int LANES  = 32,
    parameter int DATA_W = 8,
    localparam int RW    = LANES * DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          rot,
    input  logic [RW-1:0] din,
    output logic [RW-1:0] act
);

    logic [RW-1:0] rotated;

    // Build the right-rotated view lane by lane.
    for (genvar g = 0; g < LANES; g++) begin : g_rot
        localparam int SRC = (g + LANES - 1) % LANES;
        assign rotated[g*DATA_W +: DATA_W] = act[SRC*DATA_W +: DATA_W];
    end

    // Hold, load or rotate the activation row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= '0;
        end else if (load) begin
            act <= din;
        end else if (rot) begin
            act <= rotated;
        end
    end

endmodule

// File: rtl/smt_lane_mac.sv
// Module: smt_lane_mac
// Weight row register plus one signed multiplier and accumulator per lane.
// The sum is prior + act*wgt, with prior forced to zero when acc_zero is high.
// Assumes: PSUM_W >= 2*DATA_W; sums wrap modulo 2^PSUM_W.
module smt_lane_mac #(
    parameter int LANES  = 32,
    parameter int DATA_W = 8,
    parameter int PSUM_W = 24,
    localparam int RW    = LANES * DATA_W,
    localparam int PW    = LANES * PSUM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          w_load,
    input  logic [RW-1:0] w_din,
    input  logic [RW-1:0] act,
    input  logic [PW-1:0] prior,
    input  logic          acc_zero,
    output logic [PW-1:0] sum
);

    logic [RW-1:0] wgt;

    // Capture a new weight row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wgt <= '0;
        end else if (w_load) begin
            wgt <= w_din;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [DATA_W-1:0]   a_s;
        logic signed [DATA_W-1:0]   w_s;
        logic signed [2*DATA_W-1:0] prod;
        logic signed [PSUM_W-1:0]   prod_x;
        logic signed [PSUM_W-1:0]   base;

        // Multiply one lane pair and add onto the selected prior value.
        always_comb begin
            a_s    = act[g*DATA_W +: DATA_W];
            w_s    = wgt[g*DATA_W +: DATA_W];
            prod   = a_s * w_s;
            prod_x = PSUM_W'(prod);
            base   = acc_zero ? '0 : prior[g*PSUM_W +: PSUM_W];
            sum[g*PSUM_W +: PSUM_W] = base + prod_x;
        end
    end

endmodule

// File: rtl/smt_sequencer.sv
// Module: smt_sequencer
// Job sequencer: fetches the activation row once, then for each weight row
// fetches it and runs LANES steps. Each step reads a psum row, then writes
// the updated row back. Drives the single subarray port while busy.
// Assumes: subarray read latency of one cycle; addresses wrap modulo DEPTH.
module smt_sequencer
    import smt_pkg::*;
#(
    parameter int LANES = 32,
    parameter int WROWS = 3,
    parameter int AW    = 6,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int JW   = (WROWS > 1) ? $clog2(WROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear,
    input  logic [AW-1:0] act_row,
    input  logic [AW-1:0] wgt_row,
    input  logic [AW-1:0] psum_row,
    output logic          busy,
    output logic          done,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] psum_base,
    output logic          a_load,
    output logic          a_rot,
    output logic          w_load,
    output logic          acc_zero
);

    tile_state_e   state;
    logic [AW-1:0] act_q;
    logic [AW-1:0] wgt_q;
    logic [AW-1:0] psum_q;
    logic          clr_q;
    logic [LW-1:0] step;
    logic [JW-1:0] wsel;
    logic          last_step;
    logic          last_wrow;

    assign last_step = (step == LW'(LANES - 1));
    assign last_wrow = (wsel == JW'(WROWS - 1));
    assign psum_base = psum_q;

    // Advance the job phases and the step and weight-row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            act_q  <= '0;
            wgt_q  <= '0;
            psum_q <= '0;
            clr_q  <= 1'b0;
            step   <= '0;
            wsel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        act_q  <= act_row;
                        wgt_q  <= wgt_row;
                        psum_q <= psum_row;
                        clr_q  <= clear;
                        step   <= '0;
                        wsel   <= '0;
                        state  <= ST_RDA;
                    end
                end
                ST_RDA: state <= ST_RDW;
                ST_RDW: state <= ST_RDP;
                ST_RDP: state <= ST_WRP;
                ST_WRP: begin
                    if (last_step) begin
                        step <= '0;
                        if (last_wrow) begin
                            state <= ST_DONE;
                        end else begin
                            wsel  <= wsel + 1'b1;
                            state <= ST_RDW;
                        end
                    end else begin
                        step  <= step + 1'b1;
                        state <= ST_RDP;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the subarray access and datapath strobes for the current phase.
    always_comb begin
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        a_load   = 1'b0;
        a_rot    = 1'b0;
        w_load   = 1'b0;
        unique case (state)
            ST_RDA: begin
                mem_en   = 1'b1;
                mem_addr = act_q;
            end
            ST_RDW: begin
                mem_en   = 1'b1;
                mem_addr = wgt_q + AW'(wsel);
                a_load   = (wsel == '0);
            end
            ST_RDP: begin
                mem_en   = 1'b1;
                mem_addr = psum_q + AW'(step);
                w_load   = (step == '0);
            end
            ST_WRP: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = psum_q + AW'(step);
                a_rot    = 1'b1;
            end
            default: ;
        endcase
    end

    assign acc_zero = clr_q && (wsel == '0);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);

endmodule

// File: rtl/shift_mac_tile.sv
// Module: shift_mac_tile (top)
// MAC tile with a rotating activation register, a weight register, LANES
// signed multipliers and read-modify-write accumulation into a block of
// partial-sum rows of an attached single-port subarray. The host port reaches
// the subarray only while idle.
// Assumes: operand rows and the psum block do not overlap.
module shift_mac_tile #(
    parameter int LANES  = 32,
    parameter int DATA_W = 8,
    parameter int PSUM_W = 24,
    parameter int WROWS  = 3,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int RW    = LANES * DATA_W,
    localparam int PW    = LANES * PSUM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear,
    input  logic [AW-1:0] act_row,
    input  logic [AW-1:0] wgt_row,
    input  logic [AW-1:0] psum_row,
    output logic          busy,
    output logic          done,
    input  logic          host_en,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [PW-1:0] host_wdata,
    output logic [PW-1:0] host_rdata
);

    logic          eng_en;
    logic          eng_we;
    logic [AW-1:0] eng_addr;
    logic [AW-1:0] psum_base;
    logic          a_load;
    logic          a_rot;
    logic          w_load;
    logic          acc_zero;
    logic          ram_en;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [PW-1:0] ram_wdata;
    logic [PW-1:0] ram_rdata;
    logic [RW-1:0] act;
    logic [PW-1:0] mac_sum;

    smt_sequencer #(
        .LANES (LANES),
        .WROWS (WROWS),
        .AW    (AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .act_row   (act_row),
        .wgt_row   (wgt_row),
        .psum_row  (psum_row),
        .busy      (busy),
        .done      (done),
        .mem_en    (eng_en),
        .mem_we    (eng_we),
        .mem_addr  (eng_addr),
        .psum_base (psum_base),
        .a_load    (a_load),
        .a_rot     (a_rot),
        .w_load    (w_load),
        .acc_zero  (acc_zero)
    );

    // Give the single port to the engine while busy, otherwise to the host.
    always_comb begin
        if (busy) begin
            ram_en    = eng_en;
            ram_we    = eng_we;
            ram_addr  = eng_addr;
            ram_wdata = mac_sum;
        end else begin
            ram_en    = host_en;
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end
    end

    smt_subarray #(
        .DEPTH (DEPTH),
        .ROW_W (PW)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    smt_act_rotator #(
        .LANES  (LANES),
        .DATA_W (DATA_W)
    ) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (a_load),
        .rot   (a_rot),
        .din   (ram_rdata[RW-1:0]),
        .act   (act)
    );

    smt_lane_mac #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .PSUM_W (PSUM_W)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .w_load   (w_load),
        .w_din    (ram_rdata[RW-1:0]),
        .act      (act),
        .prior    (ram_rdata),
        .acc_zero (acc_zero),
        .sum      (mac_sum)
    );

    assign host_rdata = ram_rdata;

endmodule

// File: rtl/shift_mac_tile_chk.sv
// Module: shift_mac_tile_chk
// Protocol and write-region properties for shift_mac_tile, bound to every instance.
// Assumes: synchronous active-low reset shared with the tile.
module shift_mac_tile_chk #(
    parameter int LANES = 32,
    parameter int AW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          eng_we,
    input logic [AW-1:0] eng_addr,
    input logic [AW-1:0] psum_base
);

    logic [AW-1:0] wr_off;

    // Offset of an engine write from the latched psum base, modulo the address space.
    always_comb wr_off = eng_addr - psum_base;

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R9
    psum_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ({1'b0, wr_off} < (AW+1)'(LANES)));

endmodule

bind shift_mac_tile shift_mac_tile_chk #(
    .LANES (LANES),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .psum_base (psum_base)
);

// File: tb/shift_mac_tile_bench.sv
// Bench for shift_mac_tile: behavioural memory model, per-cycle control timeline,
// and full readback of all rows after every job.
module shift_mac_tile_bench;

    localparam int LANES  = 32;
    localparam int DATA_W = 8;
    localparam int PSUM_W = 24;
    localparam int WROWS  = 3;
    localparam int DEPTH  = 64;
    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = LANES * PSUM_W;
    localparam int RUN_CYC = 1 + WROWS * (1 + 2 * LANES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic [AW-1:0] act_row = '0;
    logic [AW-1:0] wgt_row = '0;
    logic [AW-1:0] psum_row = '0;
    logic          busy;
    logic          done;
    logic          host_en = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [PW-1:0] host_wdata = '0;
    logic [PW-1:0] host_rdata;

    logic [PW-1:0] model [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    shift_mac_tile #(
        .LANES (LANES), .DATA_W (DATA_W), .PSUM_W (PSUM_W),
        .WROWS (WROWS), .DEPTH (DEPTH)
    ) u_shift_mac_tile (
        .clk (clk), .rst_n (rst_n), .start (start), .clear (clear),
        .act_row (act_row), .wgt_row (wgt_row), .psum_row (psum_row),
        .busy (busy), .done (done),
        .host_en (host_en), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata)
    );

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [PW-1:0] act_v, input logic [PW-1:0] exp_v);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
        end
    endtask

    function automatic logic [PW-1:0] rand_row();
        logic [PW-1:0] r;
        for (int k = 0; k < PW / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic host_write(input int addr, input logic [PW-1:0] data);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(addr); host_wdata = data;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        model[addr] = data;
    endtask

    task automatic host_read(input int addr, output logic [PW-1:0] data);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(addr);
        @(negedge clk);
        host_en = 1'b0;
        data = host_rdata;
    endtask

    // Behavioural result of one job (R4, R5, R6): wrap-around right rotation per step.
    task automatic model_job(input int a, input int w, input int p, input logic clr);
        for (int s = 0; s < LANES; s++) begin
            for (int i = 0; i < LANES; i++) begin
                int acc;
                int k;
                acc = clr ? 0 : int'($signed(model[(p + s) % DEPTH][i*PSUM_W +: PSUM_W]));
                k = (i - s + LANES) % LANES;
                for (int j = 0; j < WROWS; j++) begin
                    acc = acc + int'($signed(model[a][k*DATA_W +: DATA_W]))
                              * int'($signed(model[(w + j) % DEPTH][i*DATA_W +: DATA_W]));
                end
                model[(p + s) % DEPTH][i*PSUM_W +: PSUM_W] = PSUM_W'(acc);
            end
        end
    endtask

    // Run one job; compare busy/done every cycle (R3) and optionally poke it mid-run (R2, R8).
    task automatic run_job(input int a, input int w, input int p, input logic clr, input bit poke);
        @(negedge clk);
        act_row = AW'(a); wgt_row = AW'(w); psum_row = AW'(p); clear = clr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= RUN_CYC + 3; k++) begin
            check(busy == (k <= RUN_CYC), (k > RUN_CYC) ? "R2 busy after job" : "R3 busy",
                  PW'(busy), PW'(k <= RUN_CYC));
            check(done == (k == RUN_CYC), "R3 done", PW'(done), PW'(k == RUN_CYC));
            if (poke && k == 50) begin
                start = 1'b1; clear = 1'b1; psum_row = '0;
                host_en = 1'b1; host_we = 1'b1; host_addr = AW'(50); host_wdata = rand_row();
            end
            @(negedge clk);
            start = 1'b0; host_en = 1'b0; host_we = 1'b0;
        end
        model_job(a, w, p, clr);
    endtask

    // Read every row back and compare against the model.
    task automatic readback(input int p, input string ptag);
        logic [PW-1:0] got;
        for (int r = 0; r < DEPTH; r++) begin
            bit in_psum;
            in_psum = ((r - p + DEPTH) % DEPTH) < LANES;
            host_read(r, got);
            check(got === model[r], in_psum ? ptag : ((r == 50) ? "R8 host write mid-job" : "R9 row kept"),
                  got, model[r]);
        end
    endtask

    initial begin
        logic [PW-1:0] got;
        repeat (3) @(negedge clk);
        // R1: outputs idle after reset
        check(busy == 1'b0, "R1 busy", PW'(busy), '0);
        check(done == 1'b0, "R1 done", PW'(done), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle", PW'({busy, done}), '0);

        for (int r = 0; r < DEPTH; r++) host_write(r, rand_row());
        // R7: host write then read returns the row one cycle later
        host_read(5, got);
        check(got === model[5], "R7 host read", got, model[5]);
        host_write(9, rand_row());
        host_read(9, got);
        check(got === model[9], "R7 host rewrite", got, model[9]);

        // R4, R5: fresh accumulation with clear
        run_job(0, 1, 32, 1'b1, 1'b0);
        readback(32, "R4 R5 clear job");

        // R5: accumulate onto existing sums with other weights
        run_job(0, 4, 32, 1'b0, 1'b0);
        readback(32, "R5 accumulate");

        // R6: extreme operands overflow the psum lanes; R2/R8 mid-run start and host write
        host_write(40, {(PW/DATA_W){8'h80}});
        for (int j = 0; j < WROWS; j++) host_write(41 + j, {(PW/DATA_W){8'h80}});
        for (int s = 0; s < LANES; s++) host_write(8 + s, {LANES{24'h7FFFFF}});
        run_job(40, 41, 8, 1'b0, 1'b1);
        readback(8, "R6 wrap");

        // R4: mixed signs with new random operands
        host_write(44, rand_row());
        for (int j = 0; j < WROWS; j++) host_write(45 + j, rand_row());
        run_job(44, 45, 0, 1'b1, 1'b0);
        readback(0, "R4 random job");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule